// File: doc/BRIEF.md
# Dual-Stream Nibble Merger with 4B/5B, NRZI and Frame Marks

This block takes two serial data channels, interleaves them bit by bit into 4-bit nibbles and maps each nibble onto a 5-bit line symbol. The symbol is sent MSB first through a one-bit serializer and coded NRZI, so the line flips on every 1. Channel B is inverted before the merge, and its bit always comes first in each interleaved pair. Because of this inversion, two idle (all-zero) channels produce the nibble 0xA.

To let a receiver find symbol boundaries without spending any bandwidth, the block overwrites the symbol of nibble 0xA with a frame mark. It does so only when the nibble that follows begins with a line transition. In that case the mark turns the five-bit line pattern into an unbroken run of ones or zeros, and the run cannot occur anywhere else. To make this decision, one nibble of look-ahead is held.

The whole block runs on one clock, gated by a bit-rate enable. Every enabled cycle emits one line bit, and five enabled cycles make one symbol period. Within a period, the two input pairs are taken on two fixed phases.

Top module: `dual_stream_framer`

## Requirements
- R1: With `rst` high (synchronous, active high), `line_out` is 0. After release, the symbol period counter starts at phase 0 and the first symbol period emits no transition.
- R2: The phase counter advances only on cycles with `bit_en` high and wraps from 4 to 0. With `bit_en` low, `line_out` and all internal state hold.
- R3: The inputs are sampled only on enabled cycles at phase 0 (pair 0) and at phase 2 (pair 1). The assembled nibble is {~b0, a0, ~b1, a1} with bit 3 first. Input values on all other cycles have no effect on the line.
- R4: Each nibble is coded with the 4B/5B data table: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R5: A symbol is emitted MSB first, one bit per enabled cycle. A nibble sampled in period k is emitted in period k+2. The look-ahead register holds nibble 0xA after reset, so period 1 carries 0xA, and period 2 carries the first sampled nibble.
- R6: NRZI: on each enabled cycle, `line_out` toggles when the emitted bit is 1 and holds when it is 0.
- R7: When nibble 0xA is followed by a nibble in {0, 2, 3, 8..F}, its symbol is replaced by 10000. This turns the line pattern 11011 into 11111, or 00100 into 00000.
- R8: When nibble 0xA is followed by a nibble in {1, 4, 5, 6, 7}, it keeps its normal symbol 10110.
- R9: With both channels held at 0, the stream is all 0xA nibbles. Every symbol is then a frame mark, and the line alternates between runs of five ones and five zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-rate enable; one line bit per enabled cycle |
| ch_a | input | 1 | Serial data of channel A (not inverted) |
| ch_b | input | 1 | Serial data of channel B (inverted before merge) |
| line_out | output | 1 | Registered NRZI line output |

## Verification
Idle channels check that every symbol becomes a frame mark and that the line settles into alternating five-bit runs. Two passes through the sixteen nibbles in order test each table entry and the emit order. Pairs of 0xA followed by every nibble value separate the set that allows the mark from the set that suppresses it. Random nibbles, with random data driven on the non-sampling phases and later with random enable stalls, show whether any input is taken on the wrong phase and whether stalls freeze the line.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
  localparam int NIB_W = 4;
  localparam int SYM_W = 5;
  localparam int PH_W  = $clog2(SYM_W);

  function automatic logic [SYM_W-1:0] enc_4b5b(input logic [NIB_W-1:0] n);
    logic [SYM_W-1:0] s;
    case (n)
      4'h0: s = 5'b11110;
      4'h1: s = 5'b01001;
      4'h2: s = 5'b10100;
      4'h3: s = 5'b10101;
      4'h4: s = 5'b01010;
      4'h5: s = 5'b01011;
      4'h6: s = 5'b01110;
      4'h7: s = 5'b01111;
      4'h8: s = 5'b10010;
      4'h9: s = 5'b10011;
      4'hA: s = 5'b10110;
      4'hB: s = 5'b10111;
      4'hC: s = 5'b11010;
      4'hD: s = 5'b11011;
      4'hE: s = 5'b11100;
      default: s = 5'b11101;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/dsf_gather.sv
module dsf_gather
  import dsf_pkg::*;
#(
  parameter logic [NIB_W-1:0] IDLE_NIB = 4'hA
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             ch_a,
  input  logic             ch_b,
  output logic             sym_load,
  output logic [PH_W-1:0]  phase,
  output logic [NIB_W-1:0] cur_nib,
  output logic [NIB_W-1:0] next_nib
);
  localparam logic [PH_W-1:0] PH_LAST  = PH_W'(SYM_W - 1);
  localparam logic [PH_W-1:0] PH_PAIR0 = '0;
  localparam logic [PH_W-1:0] PH_PAIR1 = PH_W'(2);

  logic       half_b, half_a;
  logic [NIB_W-1:0] nib_asm;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (bit_en) begin
      phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_b <= 1'b0;
      half_a <= 1'b0;
    end else if (bit_en && phase == PH_PAIR0) begin
      half_b <= ch_b;
      half_a <= ch_a;
    end
  end

  assign nib_asm = {~half_b, half_a, ~ch_b, ch_a};

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_nib  <= IDLE_NIB;
      next_nib <= IDLE_NIB;
    end else if (bit_en && phase == PH_PAIR1) begin
      cur_nib  <= next_nib;
      next_nib <= nib_asm;
    end
  end

  assign sym_load = bit_en && (phase == PH_LAST);
endmodule

// File: rtl/dsf_symbolizer.sv
module dsf_symbolizer
  import dsf_pkg::*;
#(
  parameter logic [NIB_W-1:0] FRAME_NIB = 4'hA,
  parameter bit               FRAME_EN  = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             sym_load,
  input  logic [NIB_W-1:0] cur_nib,
  input  logic [NIB_W-1:0] next_nib,
  output logic [SYM_W-1:0] sym_q,
  output logic             tx_bit
);
  localparam logic [SYM_W-1:0] MARK_SYM = {1'b1, {(SYM_W-1){1'b0}}};

  logic [SYM_W-1:0] plain_sym, next_sym, load_sym;
  logic             mark;

  assign plain_sym = enc_4b5b(cur_nib);
  assign next_sym  = enc_4b5b(next_nib);

  generate
    if (FRAME_EN) begin : g_frame
      // mark only when the following symbol opens with a transition
      assign mark = (cur_nib == FRAME_NIB) && next_sym[SYM_W-1];
    end else begin : g_plain
      assign mark = 1'b0;
    end
  endgenerate

  assign load_sym = mark ? MARK_SYM : plain_sym;

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_q <= '0;
    end else if (bit_en) begin
      sym_q <= sym_load ? load_sym : {sym_q[SYM_W-2:0], 1'b0};
    end
  end

  assign tx_bit = sym_q[SYM_W-1];
endmodule

// File: rtl/dsf_nrzi.sv
module dsf_nrzi (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic tx_bit,
  output logic line_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b0;
    end else if (bit_en) begin
      line_q <= line_q ^ tx_bit;
    end
  end
endmodule

// File: rtl/dual_stream_framer.sv
module dual_stream_framer
  import dsf_pkg::*;
#(
  parameter logic [NIB_W-1:0] IDLE_NIB = 4'hA,
  parameter bit               FRAME_EN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic ch_a,
  input  logic ch_b,
  output logic line_out
);
  logic             sym_load_w;
  logic [PH_W-1:0]  phase_w;
  logic [NIB_W-1:0] cur_w, next_w;
  logic [SYM_W-1:0] sym_w;
  logic             tx_bit_w;

  dsf_gather #(.IDLE_NIB(IDLE_NIB)) u_gather (
    .clk(clk), .rst(rst), .bit_en(bit_en), .ch_a(ch_a), .ch_b(ch_b),
    .sym_load(sym_load_w), .phase(phase_w), .cur_nib(cur_w), .next_nib(next_w)
  );

  dsf_symbolizer #(.FRAME_NIB(IDLE_NIB), .FRAME_EN(FRAME_EN)) u_sym (
    .clk(clk), .rst(rst), .bit_en(bit_en), .sym_load(sym_load_w),
    .cur_nib(cur_w), .next_nib(next_w), .sym_q(sym_w), .tx_bit(tx_bit_w)
  );

  dsf_nrzi u_nrzi (
    .clk(clk), .rst(rst), .bit_en(bit_en), .tx_bit(tx_bit_w), .line_q(line_out)
  );
endmodule

// File: rtl/dsf_checker.sv
module dsf_checker
  import dsf_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             bit_en,
  input logic             line_out,
  input logic             sym_load,
  input logic [PH_W-1:0]  phase,
  input logic [NIB_W-1:0] cur_nib,
  input logic [NIB_W-1:0] next_nib,
  input logic [SYM_W-1:0] sym_q
);
  AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(line_out)); // R2
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (bit_en && phase == PH_W'(SYM_W-1)) |=> (phase == '0)); // R2
  AST_TOGGLE_ON_ONE: assert property (@(posedge clk) disable iff (rst)
    (bit_en && sym_q[SYM_W-1]) |=> (line_out != $past(line_out))); // R6
  AST_HOLD_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !sym_q[SYM_W-1]) |=> $stable(line_out)); // R6
  AST_FRAME_MARK: assert property (@(posedge clk) disable iff (rst)
    (sym_load && cur_nib == 4'hA && (next_nib inside {4'h0, 4'h2, 4'h3, [4'h8:4'hF]}))
    |=> (sym_q == 5'b10000)); // R7
  AST_FRAME_SUPPRESS: assert property (@(posedge clk) disable iff (rst)
    (sym_load && cur_nib == 4'hA && (next_nib inside {4'h1, [4'h4:4'h7]}))
    |=> (sym_q == 5'b10110)); // R8
  AST_CODE_WEIGHT: assert property (@(posedge clk) disable iff (rst)
    (sym_load && cur_nib != 4'hA) |=> ($countones(sym_q) >= 2)); // R4
endmodule

bind dual_stream_framer dsf_checker u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .line_out(line_out),
  .sym_load(sym_load_w), .phase(phase_w), .cur_nib(cur_w),
  .next_nib(next_w), .sym_q(sym_w)
);

// File: tb/sim_dual_stream_framer.sv
`timescale 1ns/1ps
module sim_dual_stream_framer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic ch_a = 1'b0;
  logic ch_b = 1'b0;
  logic line_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_stream_framer u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .ch_a(ch_a), .ch_b(ch_b),
    .line_out(line_out)
  );

  function automatic logic [4:0] code(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  function automatic string label(input int k);
    if (k < 22)       return "R1 R5 R9 idle";
    else if (k < 54)  return "R4 R5 R6 ordered";
    else if (k < 86)  return "R7 R8 mark-select";
    else if (k < 186) return "R3 R6 random";
    else              return "R2 stalls";
  endfunction

  // nibble chosen for driven period k
  function automatic logic [3:0] pick(input int k);
    if (k < 20)      return 4'hA;
    else if (k < 52) return 4'((k - 20) % 16);
    else if (k < 84) return ((k - 52) % 2 == 0) ? 4'hA : 4'((k - 52) / 2);
    else             return 4'($urandom % 16);
  endfunction

  task automatic check(input logic got, input logic exp, input string req);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: line_out=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [3:0] nibs[$];
    logic       mline;
    int         e;
    mline = 1'b0;
    e = 0;
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      check(line_out, 1'b0, "R1 reset");
    end
    rst = 1'b0;
    while (e < 300 * 5) begin
      int k, ph;
      logic en, bitv, cur_l, nxt_l;
      logic [3:0] lc, ln;
      logic [4:0] s;
      k  = e / 5;
      ph = e % 5;
      en = (k >= 186) ? ($urandom % 4 != 0) : 1'b1;
      bit_en = en;
      ch_a = 1'($urandom);
      ch_b = 1'($urandom);
      if (en) begin
        if (ph == 0) nibs.push_back(pick(k));
        if (ph == 0) begin ch_b = ~nibs[k][3]; ch_a = nibs[k][2]; end
        if (ph == 2) begin ch_b = ~nibs[k][1]; ch_a = nibs[k][0]; end
        if (k == 0) bitv = 1'b0;
        else begin
          lc = (k == 1) ? 4'hA : nibs[k-2];
          ln = nibs[k-1];
          s  = (lc == 4'hA && code(ln)[4]) ? 5'b10000 : code(lc);
          bitv = s[4-ph];
        end
        mline = mline ^ bitv;
        e++;
      end
      cur_l = 1'b0; nxt_l = 1'b0;
      @(negedge clk);
      check(line_out, mline, label(k));
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule